// File: doc/BRIEF.md
# DMA Channel Interrupt Mask Controller

This block gathers per-channel completion events from a multi-channel DMA engine and turns them into a single interrupt line. Channels are arranged in three groups: a transmit group and a receive group, each with one bit per channel, and a small engine-level group whose bit 1 reports a host error. Each group keeps a latched raw event vector, an enable mask and the masked result. Software reads all three through a 32-bit register port.

The mask is never written directly. One address of each group turns on every bit written as 1. A second address turns off every bit written as 1. Two independent agents can therefore change different channels without a read-modify-write race.

The block also holds the engine enable bit for each direction and a soft reset register. The soft reset register clears itself after a fixed number of cycles and reads as busy until then. An end-of-interrupt write drops the interrupt line for one cycle, so a source that is still pending produces a fresh rising edge. Each raw bit is cleared by the channel's own acknowledge input, not by software.

Top module: `dma_irq_mask_ctrl`

## Requirements
- R1: After the hardware reset, every raw vector, mask, enable bit and the soft reset register reads 0. `irq`, `tx_en` and `rx_en` are low.
- R2: Bit 0 of offset 0x04 is the transmit enable and bit 0 of offset 0x14 is the receive enable. Each is read/write, drives `tx_en` or `rx_en`, and reads back with all other bits 0.
- R3: Mask changes work as follows. Writing 1 to a bit at a group's set offset (transmit 0x88, receive 0xA8, engine 0xB8) enables that bit. Writing 1 to a bit at the group's clear offset (0x8C, 0xAC, 0xBC) disables it. Bits written as 0 leave the mask unchanged.
- R4: A read of either the set offset or the clear offset returns the group's current mask.
- R5: A raw bit is set by a one-cycle pulse on its event input and stays set until its acknowledge input is high. If the event and the acknowledge arrive in the same cycle, the bit ends up set. Acknowledging one bit leaves the other bits unchanged. The raw vectors read at 0x80, 0xA0 and 0xB0.
- R6: The masked vector (0x84, 0xA4, 0xB4) is the raw vector ANDed with the mask. `irq` goes high one cycle after any masked bit in any group is set, and goes low one cycle after none is set.
- R7: The transmit group and the receive group are independent. Events, acknowledges and mask writes in one group leave the other group unchanged.
- R8: The host-error event sets bit 1 of the engine group (0xB0). Bit 0 of that group always reads 0. The host-error acknowledge clears bit 1.
- R9: Any write to offset 0x94 (end of interrupt) forces `irq` low in the following cycle. If a masked bit is still set, `irq` returns high in the cycle after that.
- R10: Writes to the raw and masked offsets, and to any unmapped offset, change nothing. Unmapped offsets read 0.
- R11: Writing 1 to bit 0 of offset 0x1C starts a soft reset. The soft reset clears all raw vectors, masks and enable bits. Offset 0x1C then reads 1 for exactly SRST_CYCLES consecutive reads and reads 0 after that.
- R12: While a soft reset is in progress, register writes and channel events are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; `rdata` updates on the next edge |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| tx_evt | input | NUM_CH | Transmit channel event pulses |
| tx_ack | input | NUM_CH | Transmit channel acknowledges |
| rx_evt | input | NUM_CH | Receive channel event pulses |
| rx_ack | input | NUM_CH | Receive channel acknowledges |
| herr_evt | input | 1 | Host-error event pulse |
| herr_ack | input | 1 | Host-error acknowledge |
| tx_en | output | 1 | Transmit engine enable |
| rx_en | output | 1 | Receive engine enable |
| irq | output | 1 | Interrupt line |

## Verification
The assertions assume the following about the inputs:
- Event and acknowledge inputs are synchronous to `clk` and hold one bit per channel.
- Register accesses use word-aligned offsets.
- A write and a read to the same register are never issued in the same cycle.

The stimulus respects these assumptions. It changes every input on the falling edge and issues one register access at a time. It may pulse an event and an acknowledge on the same bit together, which covers the overlap ordering. It also raises events and writes during a soft reset, which covers the ignore rule.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

  localparam int REG_AW = 8;
  localparam int REG_DW = 32;

  // byte offsets; a group occupies four consecutive words from its base
  localparam logic [REG_AW-1:0] OFS_TX_ENA   = 8'h04;
  localparam logic [REG_AW-1:0] OFS_RX_ENA   = 8'h14;
  localparam logic [REG_AW-1:0] OFS_SRST     = 8'h1C;
  localparam logic [REG_AW-1:0] OFS_EOI      = 8'h94;
  localparam logic [REG_AW-1:0] BASE_TX_GRP  = 8'h80;
  localparam logic [REG_AW-1:0] BASE_RX_GRP  = 8'hA0;
  localparam logic [REG_AW-1:0] BASE_ENG_GRP = 8'hB0;

  // word slot inside a group
  typedef enum logic [1:0] {
    SLOT_RAW    = 2'd0,
    SLOT_MASKED = 2'd1,
    SLOT_SET    = 2'd2,
    SLOT_CLR    = 2'd3
  } grp_slot_e;

  // decoded write strobes, at most one high per cycle
  typedef struct packed {
    logic tx_set;
    logic tx_clr;
    logic rx_set;
    logic rx_clr;
    logic eng_set;
    logic eng_clr;
    logic tx_ena;
    logic rx_ena;
    logic srst;
    logic eoi;
  } wr_strobe_t;

  function automatic logic [REG_AW-3:0] word_of(input logic [REG_AW-1:0] ofs);
    return ofs[REG_AW-1:2];
  endfunction

  function automatic logic grp_hit(input logic [REG_AW-1:0] a,
                                   input logic [REG_AW-1:0] base);
    return a[REG_AW-1:4] == base[REG_AW-1:4];
  endfunction

endpackage

// File: rtl/irq_bank.sv
module irq_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         soft_clr,
  input  logic [W-1:0] evt,
  input  logic [W-1:0] ack,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] wbits,
  output logic [W-1:0] raw_o,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] masked_o,
  output logic         any_o
);

  // an event outranks an acknowledge arriving in the same cycle
  function automatic logic [W-1:0] raw_next(input logic [W-1:0] cur,
                                            input logic [W-1:0] e,
                                            input logic [W-1:0] a);
    return (cur & ~a) | e;
  endfunction

  function automatic logic [W-1:0] mask_next(input logic [W-1:0] cur,
                                             input logic [W-1:0] bits,
                                             input logic s,
                                             input logic c);
    logic [W-1:0] r;
    r = cur;
    if (s) r = r | bits;
    if (c) r = r & ~bits;
    return r;
  endfunction

  logic [W-1:0] raw_q;
  logic [W-1:0] mask_q;
  logic [W-1:0] raw_d;
  logic [W-1:0] mask_d;

  always_comb begin
    raw_d  = raw_next(raw_q, evt, ack);
    mask_d = mask_next(mask_q, wbits, set_we, clr_we);
  end

  // per-bit registers so each channel lane stays separable in layout
  for (genvar i = 0; i < W; i++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        raw_q[i]  <= 1'b0;
        mask_q[i] <= 1'b0;
      end else if (soft_clr) begin
        raw_q[i]  <= 1'b0;
        mask_q[i] <= 1'b0;
      end else begin
        raw_q[i]  <= raw_d[i];
        mask_q[i] <= mask_d[i];
      end
    end
  end

  assign raw_o    = raw_q;
  assign mask_o   = mask_q;
  assign masked_o = raw_q & mask_q;
  assign any_o    = |masked_o;

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ack & ~evt)) && !soft_clr |=> ((raw_o & $past(ack & ~evt)) == '0)); // R5

  AST_RAW_NEEDS_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw_o & ~$past(raw_o) & ~$past(evt)) == '0)); // R5

  AST_MASK_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !set_we && !clr_we && !soft_clr |=> $stable(mask_o)); // R3

  AST_SET_ADDS: assert property (@(posedge clk) disable iff (!rst_n)
    set_we && !soft_clr |=> ((mask_o & $past(wbits)) == $past(wbits))); // R3

  AST_CLR_REMOVES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we && !soft_clr |=> ((mask_o & $past(wbits)) == '0)); // R3

  AST_SOFT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (raw_o == '0) && (mask_o == '0)); // R11

endmodule

// File: rtl/srst_seq.sv
module srst_seq #(
  parameter int CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);

  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (start && !busy) cnt_q <= LOAD;
    else if (busy)           cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);

  AST_SRST_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (cnt_q == $past(cnt_q) - 1'b1)); // R11

  AST_SRST_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LOAD); // R11

endmodule

// File: rtl/reg_decode.sv
module reg_decode
  import dma_irq_pkg::*;
(
  input  logic              wr_en,
  input  logic              busy,
  input  logic [REG_AW-1:0] addr,
  output wr_strobe_t        stb
);

  logic [REG_AW-3:0] w;
  logic              go;
  grp_slot_e         slot;

  assign w    = addr[REG_AW-1:2];
  assign go   = wr_en && !busy;
  assign slot = grp_slot_e'(addr[3:2]);

  always_comb begin
    stb         = '0;
    stb.tx_set  = go && grp_hit(addr, BASE_TX_GRP)  && (slot == SLOT_SET);
    stb.tx_clr  = go && grp_hit(addr, BASE_TX_GRP)  && (slot == SLOT_CLR);
    stb.rx_set  = go && grp_hit(addr, BASE_RX_GRP)  && (slot == SLOT_SET);
    stb.rx_clr  = go && grp_hit(addr, BASE_RX_GRP)  && (slot == SLOT_CLR);
    stb.eng_set = go && grp_hit(addr, BASE_ENG_GRP) && (slot == SLOT_SET);
    stb.eng_clr = go && grp_hit(addr, BASE_ENG_GRP) && (slot == SLOT_CLR);
    stb.tx_ena  = go && (w == word_of(OFS_TX_ENA));
    stb.rx_ena  = go && (w == word_of(OFS_RX_ENA));
    stb.srst    = go && (w == word_of(OFS_SRST));
    stb.eoi     = go && (w == word_of(OFS_EOI));
  end

  AST_ONE_STROBE: assert final ($onehot0(stb)); // R10

endmodule

// File: rtl/dma_irq_mask_ctrl.sv
module dma_irq_mask_ctrl
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int SRST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [REG_DW-1:0] wdata,
  output logic [REG_DW-1:0] rdata,
  input  logic [NUM_CH-1:0] tx_evt,
  input  logic [NUM_CH-1:0] tx_ack,
  input  logic [NUM_CH-1:0] rx_evt,
  input  logic [NUM_CH-1:0] rx_ack,
  input  logic              herr_evt,
  input  logic              herr_ack,
  output logic              tx_en,
  output logic              rx_en,
  output logic              irq
);

  localparam int ENG_W    = 2;
  localparam int HERR_BIT = 1;

  wr_strobe_t stb;
  logic       busy;
  logic       srst_start;

  // named internal events for the assertions
  logic tx_any, rx_any, eng_any, src_any;

  logic [NUM_CH-1:0] tx_raw, tx_mask, tx_msk;
  logic [NUM_CH-1:0] rx_raw, rx_mask, rx_msk;
  logic [ENG_W-1:0]  eng_raw, eng_mask, eng_msk;
  logic [ENG_W-1:0]  eng_evt, eng_ack;

  logic unused_bits;
  assign unused_bits = ^{wdata[REG_DW-1:NUM_CH], addr[1:0]};

  reg_decode u_dec (
    .wr_en (wr_en),
    .busy  (busy),
    .addr  (addr),
    .stb   (stb)
  );

  assign srst_start = stb.srst && wdata[0];

  srst_seq #(.CYCLES(SRST_CYCLES)) u_srst (
    .clk   (clk),
    .rst_n (rst_n),
    .start (srst_start),
    .busy  (busy)
  );

  irq_bank #(.W(NUM_CH)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_clr (busy),
    .evt      (tx_evt),
    .ack      (tx_ack),
    .set_we   (stb.tx_set),
    .clr_we   (stb.tx_clr),
    .wbits    (wdata[NUM_CH-1:0]),
    .raw_o    (tx_raw),
    .mask_o   (tx_mask),
    .masked_o (tx_msk),
    .any_o    (tx_any)
  );

  irq_bank #(.W(NUM_CH)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_clr (busy),
    .evt      (rx_evt),
    .ack      (rx_ack),
    .set_we   (stb.rx_set),
    .clr_we   (stb.rx_clr),
    .wbits    (wdata[NUM_CH-1:0]),
    .raw_o    (rx_raw),
    .mask_o   (rx_mask),
    .masked_o (rx_msk),
    .any_o    (rx_any)
  );

  // engine group: only the host-error lane has a source
  for (genvar b = 0; b < ENG_W; b++) begin : g_eng_src
    if (b == HERR_BIT) begin : g_herr
      assign eng_evt[b] = herr_evt;
      assign eng_ack[b] = herr_ack;
    end else begin : g_none
      assign eng_evt[b] = 1'b0;
      assign eng_ack[b] = 1'b0;
    end
  end

  irq_bank #(.W(ENG_W)) u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_clr (busy),
    .evt      (eng_evt),
    .ack      (eng_ack),
    .set_we   (stb.eng_set),
    .clr_we   (stb.eng_clr),
    .wbits    (wdata[ENG_W-1:0]),
    .raw_o    (eng_raw),
    .mask_o   (eng_mask),
    .masked_o (eng_msk),
    .any_o    (eng_any)
  );

  assign src_any = tx_any | rx_any | eng_any;

  // engine enables
  logic tx_en_q, rx_en_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_en_q <= 1'b0;
      rx_en_q <= 1'b0;
    end else if (busy) begin
      tx_en_q <= 1'b0;
      rx_en_q <= 1'b0;
    end else begin
      if (stb.tx_ena) tx_en_q <= wdata[0];
      if (stb.rx_ena) rx_en_q <= wdata[0];
    end
  end
  assign tx_en = tx_en_q;
  assign rx_en = rx_en_q;

  // interrupt line, dropped for one cycle by end-of-interrupt
  logic irq_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= src_any && !stb.eoi && !busy;
  end
  assign irq = irq_q;

  // read mux
  function automatic logic [REG_DW-1:0] grp_word(input grp_slot_e s,
                                                 input logic [REG_DW-1:0] r,
                                                 input logic [REG_DW-1:0] m);
    case (s)
      SLOT_RAW:    return r;
      SLOT_MASKED: return r & m;
      default:     return m;
    endcase
  endfunction

  logic [REG_DW-1:0] rd_val;
  always_comb begin
    rd_val = '0;
    if (grp_hit(addr, BASE_TX_GRP))
      rd_val = grp_word(grp_slot_e'(addr[3:2]), REG_DW'(tx_raw), REG_DW'(tx_mask));
    else if (grp_hit(addr, BASE_RX_GRP))
      rd_val = grp_word(grp_slot_e'(addr[3:2]), REG_DW'(rx_raw), REG_DW'(rx_mask));
    else if (grp_hit(addr, BASE_ENG_GRP))
      rd_val = grp_word(grp_slot_e'(addr[3:2]), REG_DW'(eng_raw), REG_DW'(eng_mask));
    else if (addr[REG_AW-1:2] == word_of(OFS_TX_ENA))
      rd_val = REG_DW'(tx_en_q);
    else if (addr[REG_AW-1:2] == word_of(OFS_RX_ENA))
      rd_val = REG_DW'(rx_en_q);
    else if (addr[REG_AW-1:2] == word_of(OFS_SRST))
      rd_val = REG_DW'(busy);
  end

  logic [REG_DW-1:0] rdata_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_val;
  end
  assign rdata = rdata_q;

  AST_EOI_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    stb.eoi |=> !irq); // R9

  AST_IRQ_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(src_any)); // R6

  AST_IRQ_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
    src_any && !stb.eoi && !busy |=> irq); // R6

  AST_ENG_BIT0_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_raw[0]); // R8

  AST_BUSY_ENABLES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !tx_en && !rx_en); // R11

endmodule

// File: tb/dma_irq_mask_ctrl_test.sv
`timescale 1ns/1ps
module dma_irq_mask_ctrl_test;

  localparam int NCH  = 8;
  localparam int SRSTC = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NCH-1:0] tx_evt = '0, tx_ack = '0, rx_evt = '0, rx_ack = '0;
  logic        herr_evt = 1'b0, herr_ack = 1'b0;
  logic        tx_en, rx_en, irq;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dma_irq_mask_ctrl #(.NUM_CH(NCH), .SRST_CYCLES(SRSTC)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tx_evt(tx_evt), .tx_ack(tx_ack),
    .rx_evt(rx_evt), .rx_ack(rx_ack), .herr_evt(herr_evt), .herr_ack(herr_ack),
    .tx_en(tx_en), .rx_en(rx_en), .irq(irq)
  );

  // scoreboard
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  always @(posedge clk) rd_seen <= rd_en;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        errors++; checks++;
        $display("FAIL scoreboard: read result with no expectation, actual %h expected none", rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (rdata !== e) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", t, rdata, e);
        end
      end
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic chk(input logic act, input logic e, input string t);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", t, act, e);
    end
  endtask

  task automatic pulse_tx(input logic [NCH-1:0] ev, input logic [NCH-1:0] ak);
    tx_evt = ev; tx_ack = ak;
    @(negedge clk);
    tx_evt = '0; tx_ack = '0;
  endtask

  task automatic pulse_rx(input logic [NCH-1:0] ev, input logic [NCH-1:0] ak);
    rx_evt = ev; rx_ack = ak;
    @(negedge clk);
    rx_evt = '0; rx_ack = '0;
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);

    // R1 reset state
    chk(irq, 1'b0, "R1 irq after reset");
    chk(tx_en, 1'b0, "R1 tx_en after reset");
    chk(rx_en, 1'b0, "R1 rx_en after reset");
    rd(8'h80, 32'h0, "R1 tx raw");
    rd(8'h88, 32'h0, "R1 tx mask");
    rd(8'hA8, 32'h0, "R1 rx mask");
    rd(8'h1C, 32'h0, "R1 soft reset idle");

    // R2 enables
    wr(8'h04, 32'h1);
    chk(tx_en, 1'b1, "R2 tx_en set");
    rd(8'h04, 32'h1, "R2 tx enable readback");
    wr(8'h14, 32'hFFFF_FFFF);
    chk(rx_en, 1'b1, "R2 rx_en set");
    rd(8'h14, 32'h1, "R2 rx enable only bit0");
    wr(8'h04, 32'h0);
    chk(tx_en, 1'b0, "R2 tx_en cleared");

    // R3 / R4 mask set and clear
    wr(8'h88, 32'hA5);
    rd(8'h88, 32'hA5, "R3 set adds bits");
    rd(8'h8C, 32'hA5, "R4 clear address reads mask");
    wr(8'h8C, 32'h05);
    rd(8'h88, 32'hA0, "R3 clear removes bits");
    wr(8'h88, 32'h0);
    wr(8'h8C, 32'h0);
    rd(8'h8C, 32'hA0, "R3 zero writes no effect");

    // R5 / R6 raw and masked
    pulse_tx(8'h0F, 8'h00);
    rd(8'h80, 32'h0F, "R5 raw latched");
    rd(8'h84, 32'h00, "R6 masked none");
    tick(2);
    chk(irq, 1'b0, "R6 irq low when nothing masked");
    wr(8'h88, 32'h01);
    rd(8'h84, 32'h01, "R6 masked after enable");
    tick(1);
    chk(irq, 1'b1, "R6 irq high");

    // R9 end of interrupt
    wr(8'h94, 32'h0);
    chk(irq, 1'b0, "R9 irq drops after eoi");
    tick(1);
    chk(irq, 1'b1, "R9 irq returns while pending");

    // R5 acknowledge
    pulse_tx(8'h00, 8'h01);
    rd(8'h80, 32'h0E, "R5 ack clears one bit only");
    tick(1);
    chk(irq, 1'b0, "R6 irq low after ack");
    pulse_tx(8'h10, 8'h10);
    rd(8'h80, 32'h1E, "R5 event wins over ack");

    // R7 receive group independence
    pulse_rx(8'h80, 8'h00);
    wr(8'hA8, 32'h80);
    rd(8'hA4, 32'h80, "R7 rx masked");
    rd(8'hA0, 32'h80, "R7 rx raw");
    rd(8'h80, 32'h1E, "R7 tx raw untouched");
    rd(8'h88, 32'hA1, "R7 tx mask untouched");
    chk(irq, 1'b1, "R7 irq from rx");
    pulse_rx(8'h00, 8'h80);
    tick(1);
    chk(irq, 1'b0, "R7 irq low after rx ack");

    // R8 host error
    herr_evt = 1'b1; tick(1); herr_evt = 1'b0;
    rd(8'hB0, 32'h2, "R8 host error bit1");
    rd(8'hB4, 32'h0, "R8 host error masked off");
    wr(8'hB8, 32'h3);
    rd(8'hB4, 32'h2, "R8 host error masked on");
    tick(1);
    chk(irq, 1'b1, "R8 irq from host error");
    herr_ack = 1'b1; tick(1); herr_ack = 1'b0;
    rd(8'hB0, 32'h0, "R8 host error ack");
    chk(irq, 1'b0, "R8 irq low after ack");

    // R10 read-only and unmapped
    wr(8'h80, 32'hFF);
    wr(8'h84, 32'hFF);
    wr(8'h40, 32'hFFFF_FFFF);
    rd(8'h80, 32'h1E, "R10 raw write ignored");
    rd(8'h88, 32'hA1, "R10 mask unchanged");
    rd(8'h40, 32'h0, "R10 unmapped reads zero");

    // R11 soft reset
    wr(8'h04, 32'h1);
    wr(8'h1C, 32'h1);
    for (int i = 1; i <= SRSTC + 1; i++)
      rd(8'h1C, (i <= SRSTC) ? 32'h1 : 32'h0, "R11 soft reset busy window");
    rd(8'h80, 32'h0, "R11 raw cleared");
    rd(8'h88, 32'h0, "R11 tx mask cleared");
    rd(8'hA8, 32'h0, "R11 rx mask cleared");
    chk(tx_en, 1'b0, "R11 tx_en cleared");
    chk(rx_en, 1'b0, "R11 rx_en cleared");

    // R12 ignored during soft reset
    wr(8'h1C, 32'h1);
    wr(8'h88, 32'hFF);
    pulse_tx(8'hFF, 8'h00);
    tick(SRSTC + 1);
    rd(8'h88, 32'h0, "R12 mask write ignored while busy");
    rd(8'h80, 32'h0, "R12 events ignored while busy");
    chk(irq, 1'b0, "R12 irq low");

    tick(3);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard drain: actual %0d pending expected 0", exp_q.size());
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule